// File: doc/BRIEF.md
# Non-Retriggerable One-Shot Pulse Generator

This block makes one output pulse of a programmable number of clock cycles each time a qualified trigger edge arrives. It has two trigger inputs. Input A fires on a falling edge and input B fires on a rising edge. Each input acts as the enable of the other: A only fires while B is high, and B only fires while A is low. The pulse length comes from a per-channel width input counted in clock cycles. Once a pulse is running, the channel ignores every further trigger until the pulse ends, so triggers are never stacked or queued.

Each channel has an active-low clear input that ends a running pulse and holds the outputs idle for as long as it stays low. Releasing the clear can start a pulse on its own, but only when an arming sequence took place while the clear was low: first A high or B low, then A low and B high. The levels at release must also be A low and B high.

The outputs are a complementary pair, Q (active high) and Qn. The trigger inputs and the clear are asynchronous to the clock and each passes through a two-flop synchronizer. The width input is taken to be synchronous to the clock. A parameter sets the number of independent channels, two by default.

Top module: `os_oneshot`

## Requirements
- R1: After power-on reset (`rst_n` low at a clock edge) every channel shows q=0 and qn=1 and is disarmed. Input levels present while reset is released start no pulse during the first three clock edges after release.
- R2: When A falls while B is high (and clear is high), q goes high after the third rising clock edge following the input change.
- R3: When B rises while A is low (and clear is high), q goes high after the third rising clock edge following the input change.
- R4: A pulse lasts exactly W clock cycles, where W is the unsigned width value present at the clock edge that starts the pulse. A change to the width during the pulse does not change its length. The length does not depend on how long the trigger input is held.
- R5: While q is high, edges on A, B or clear release are ignored, and no pulse follows from them after the current pulse ends.
- R6: A trigger that arrives while the width is zero produces no pulse, and it is not kept for later.
- R7: When clear goes low, q goes low after the third rising clock edge following the change. While clear stays low, q stays 0, qn stays 1, and edges on A and B start nothing.
- R8: A rising clear with A low and B high starts a pulse (same three-edge latency) only if, during the clear-low interval, A was high or B was low at some point and afterwards A was low and B was high.
- R9: A clear release without that sequence starts no pulse. Each release disarms the channel, so a later release needs a fresh arming sequence.
- R10: qn is always the complement of q.
- R11: Channels are independent. Activity on one channel never changes the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| trig_a | input | CHANNELS | Falling-edge trigger per channel, asynchronous |
| trig_b | input | CHANNELS | Rising-edge trigger per channel, asynchronous |
| clr_n | input | CHANNELS | Active-low pulse clear per channel, asynchronous |
| width | input | CHANNELS*WIDTH_W | Pulse length in cycles; channel c uses bits [c*WIDTH_W +: WIDTH_W] |
| q | output | CHANNELS | Pulse output, active high |
| qn | output | CHANNELS | Complement of q |

## Verification
The bench aims at the timing rules, where an off-by-one error is easy to make. A pulse that lasts W±1 cycles, or a width sampled late, shows up when the width is changed in the middle of a pulse. A design that retriggers, or that queues triggers, stretches or repeats the pulse when edges are applied during a pulse or while the width is zero. The reset-release path is tested both with and without the arming sequence. A design that fires on any release, or that does not disarm afterwards, produces a pulse where none is expected. Edges applied while clear is low must not leak through. Long random runs on both channels compare every cycle against a reference model built from the requirements.

// File: rtl/os_pkg.sv
// Package: shared types for the one-shot pulse generator.
// Assumes nothing beyond the one-shot channel structure.
package os_pkg;
    // Levels of the three asynchronous control inputs of one channel
    typedef struct packed {
        logic a;      // falling-edge trigger
        logic b;      // rising-edge trigger
        logic clr;    // active-low clear
    } os_lvl_t;
endpackage

// File: rtl/os_sync.sv
// Module: os_sync
// Brings the three asynchronous control levels of a channel into the clock
// domain through a chain of STAGES flops. Assumes each input is held stable
// long enough to be seen at a clock edge.
module os_sync
    import os_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  os_lvl_t d,
    output os_lvl_t o
);
    os_lvl_t chain [STAGES];

    // Shift the sampled levels along the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign o = chain[STAGES-1];
endmodule

// File: rtl/os_trigger.sv
// Module: os_trigger
// Qualifies trigger edges on synchronized levels: A falling while B is high,
// B rising while A is low, or a clear release with A low and B high after an
// arming sequence. Edges are ignored until the synchronizer and the previous-
// sample register hold real data after power-on reset.
module os_trigger
    import os_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  os_lvl_t lvl,
    input  logic    busy,
    input  logic    width_zero,
    output logic    start,
    output logic    clear
);
    localparam int FILL = SYNC_STAGES + 1;
    localparam int FW   = $clog2(FILL + 1);

    os_lvl_t       prv;
    logic [FW-1:0] fill;
    logic          ready;
    logic          seen;
    logic          armed;
    logic          fall_a, rise_b, rise_clr;

    // Hold the previous synchronized sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prv <= '0;
        else        prv <= lvl;
    end

    // Count edges after reset until both samples carry real input data
    always_ff @(posedge clk) begin
        if (!rst_n)                 fill <= '0;
        else if (fill != FW'(FILL)) fill <= fill + 1'b1;
    end

    assign ready = (fill == FW'(FILL));

    // Track the arming sequence during a clear-low interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            armed <= 1'b0;
        end else if (ready) begin
            if (lvl.clr) begin
                seen  <= 1'b0;
                armed <= 1'b0;
            end else begin
                if (lvl.a || !lvl.b)              seen  <= 1'b1;
                if (seen && !lvl.a && lvl.b)      armed <= 1'b1;
            end
        end
    end

    assign fall_a   = prv.a && !lvl.a && lvl.b;
    assign rise_b   = !prv.b && lvl.b && !lvl.a;
    assign rise_clr = !prv.clr && lvl.clr && !lvl.a && lvl.b && armed;

    assign start = ready && lvl.clr && !busy && !width_zero
                   && (fall_a || rise_b || rise_clr);
    assign clear = ready && !lvl.clr;

    // R1
    // warmup_quiet_chk: no pulse before the synchronizer holds real data
    warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !start);

    // R6
    // zero_width_chk: a zero width never starts a pulse
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !width_zero);

    // R7
    // clr_block_chk: nothing starts while clear is low
    clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !start);

    // R9
    // disarm_chk: clear high leaves the channel disarmed
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && lvl.clr) |=> !armed);
endmodule

// File: rtl/os_timer.sv
// Module: os_timer
// Pulse length counter. It loads the width on start, counts down to zero and
// is cleared at once by clear. busy is high while the count is non-zero.
// Assumes start and clear are never high together.
module os_timer #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               clear,
    input  logic [WIDTH_W-1:0] width,
    output logic               busy
);
    logic [WIDTH_W-1:0] cnt;

    // Load, count down or clear the remaining pulse length
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clear)      cnt <= '0;
        else if (start)      cnt <= width;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7
    // clear_kill_chk: clear empties the counter on the next edge
    clear_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R4
    // load_width_chk: the counter takes the width present at start
    load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == $past(width)));

    // R4
    // countdown_chk: a running pulse loses exactly one cycle per edge
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear && !start) |=> (cnt == $past(cnt) - 1'b1));

    // R5
    // no_retrig_chk: start only arrives while idle
    no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/os_oneshot.sv
// Module: os_oneshot (top)
// CHANNELS independent non-retriggerable one-shots. Each channel has a
// synchronizer, a trigger qualifier and a width counter. The width input is
// taken to be synchronous to clk. q is the counter's busy flag, qn its inverse.
module os_oneshot
    import os_pkg::*;
#(
    parameter int CHANNELS    = 2,
    parameter int WIDTH_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CHANNELS-1:0]         trig_a,
    input  logic [CHANNELS-1:0]         trig_b,
    input  logic [CHANNELS-1:0]         clr_n,
    input  logic [CHANNELS*WIDTH_W-1:0] width,
    output logic [CHANNELS-1:0]         q,
    output logic [CHANNELS-1:0]         qn
);
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        os_lvl_t            raw, syn;
        logic               start, clear, busy;
        logic [WIDTH_W-1:0] w;

        assign raw = '{a: trig_a[c], b: trig_b[c], clr: clr_n[c]};
        assign w   = width[c*WIDTH_W +: WIDTH_W];

        os_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw), .o(syn)
        );

        os_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
            .clk(clk), .rst_n(rst_n), .lvl(syn), .busy(busy),
            .width_zero(w == '0), .start(start), .clear(clear)
        );

        os_timer #(.WIDTH_W(WIDTH_W)) u_timer (
            .clk(clk), .rst_n(rst_n), .start(start), .clear(clear),
            .width(w), .busy(busy)
        );

        assign q[c]  = busy;
        assign qn[c] = !busy;

        // R10
        // compl_out_chk: the output pair is complementary
        compl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q[c] != qn[c]);
    end
endmodule

// File: tb/tb_os_oneshot.sv
module tb_os_oneshot;
    localparam int CH = 2;
    localparam int WW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [CH-1:0]     a, b, clr;
    logic [CH*WW-1:0]  width;
    logic [CH-1:0]     q, qn;

    int    vectors = 0;
    int    fails   = 0;
    string tag     = "R1";
    bit    done    = 0;

    os_oneshot #(.CHANNELS(CH), .WIDTH_W(WW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .trig_a(a), .trig_b(b), .clr_n(clr),
        .width(width), .q(q), .qn(qn)
    );

    always #2 clk = ~clk;

    // Reference model state, per channel: input history (newest first)
    logic [2:0] ha [CH];
    logic [2:0] hb [CH];
    logic [2:0] hc [CH];
    int         m_age [CH];
    int         m_left [CH];
    bit         m_seen [CH];
    bit         m_arm [CH];

    function automatic bit fires(bit pa, bit na, bit pb, bit nb, bit pc,
                                 bit nc, bit arm);
        bit ev;
        ev = (pa && !na && nb) || (!pb && nb && !na)
             || (!pc && nc && !na && nb && arm);
        return nc && ev;
    endfunction

    // Model update at each clock edge from the pad levels it sees
    always @(posedge clk) begin
        for (int c = 0; c < CH; c++) begin
            int  w;
            bit  rdy, go, s2, n_seen, n_arm;
            w = int'(width[c*WW +: WW]);
            if (!rst_n) begin
                ha[c] = 0; hb[c] = 0; hc[c] = 0;
                m_age[c] = 0; m_left[c] = 0; m_seen[c] = 0; m_arm[c] = 0;
            end else begin
                rdy = (m_age[c] >= 3);
                go  = rdy && m_left[c] == 0 && w != 0 &&
                      fires(ha[c][2], ha[c][1], hb[c][2], hb[c][1],
                            hc[c][2], hc[c][1], m_arm[c]);
                s2  = hc[c][1];
                if (rdy && !s2)      m_left[c] = 0;
                else if (go)         m_left[c] = w;
                else if (m_left[c] > 0) m_left[c] = m_left[c] - 1;
                n_seen = m_seen[c]; n_arm = m_arm[c];
                if (rdy) begin
                    if (s2) begin n_seen = 0; n_arm = 0; end
                    else begin
                        if (ha[c][1] || !hb[c][1]) n_seen = 1;
                        if (m_seen[c] && !ha[c][1] && hb[c][1]) n_arm = 1;
                    end
                end
                m_seen[c] = n_seen; m_arm[c] = n_arm;
                if (m_age[c] < 3) m_age[c]++;
                ha[c] = {ha[c][1:0], a[c]};
                hb[c] = {hb[c][1:0], b[c]};
                hc[c] = {hc[c][1:0], clr[c]};
            end
        end
    end

    // Compare outputs against the model half a cycle after each edge
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < CH; c++) begin
                bit eq;
                eq = (m_left[c] != 0);
                vectors++;
                if (q[c] !== eq || qn[c] !== !eq) begin
                    fails++;
                    $display("FAIL %s (R10/R11 pair) ch%0d: q=%b qn=%b expected q=%b qn=%b",
                             tag, c, q[c], qn[c], eq, !eq);
                end
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic setw(int c, int w);
        width[c*WW +: WW] = WW'(w);
    endtask

    initial begin
        void'($urandom(32'h5eed_0a11));
        rst_n = 0; a = '1; b = '0; clr = '1; width = '0;
        setw(0, 5); setw(1, 5);
        // R1: idle after power-on reset
        tag = "R1"; cyc(4); rst_n = 1; cyc(10);
        // R1: enabling levels held through reset do not fire
        rst_n = 0; a[0] = 0; b[0] = 1; cyc(3); rst_n = 1; cyc(12);
        a[0] = 1; b[0] = 0; cyc(4);
        // R2: A falls while B high
        tag = "R2"; b[0] = 1; cyc(4); a[0] = 0; cyc(1); a[0] = 1; cyc(10);
        // R3: B rises while A low
        tag = "R3"; b[0] = 0; a[0] = 0; cyc(4); b[0] = 1; cyc(12);
        // R4: width change during the pulse, long trigger hold
        tag = "R4"; b[0] = 0; cyc(4); setw(0, 10); b[0] = 1; cyc(5);
        setw(0, 2); cyc(12); setw(0, 7);
        // R5: edges during a pulse are ignored
        tag = "R5"; a[0] = 1; cyc(3); a[0] = 0; cyc(4);
        b[0] = 0; cyc(1); b[0] = 1; cyc(1); a[0] = 1; cyc(1); a[0] = 0; cyc(12);
        // R6: zero width trigger is dropped
        tag = "R6"; setw(0, 0); b[0] = 0; cyc(3); b[0] = 1; cyc(4);
        setw(0, 4); cyc(10);
        // R7: clear cuts a pulse and blocks triggers
        tag = "R7"; setw(0, 20); b[0] = 0; cyc(3); b[0] = 1; cyc(6);
        clr[0] = 0; cyc(4); a[0] = 1; cyc(2); a[0] = 0; cyc(2);
        b[0] = 0; cyc(2); b[0] = 1; cyc(6);
        // R8: armed release fires (sequence above armed it)
        tag = "R8"; setw(0, 6); clr[0] = 1; cyc(12);
        // R9: release without arming sequence does nothing
        tag = "R9"; clr[0] = 0; cyc(8); clr[0] = 1; cyc(8);
        clr[0] = 0; cyc(4); clr[0] = 1; cyc(8);
        // R8: arm via B low then B high
        tag = "R8"; clr[0] = 0; cyc(3); b[0] = 0; cyc(3); b[0] = 1; cyc(3);
        clr[0] = 1; cyc(10);
        // R11: other channel triggers alone
        tag = "R11"; setw(1, 9); b[1] = 1; cyc(3); a[1] = 0; cyc(14);
        // R10: random traffic on both channels
        tag = "R10";
        for (int k = 0; k < 4000; k++) begin
            for (int c = 0; c < CH; c++) begin
                if ($urandom_range(7) == 0) a[c] = ~a[c];
                if ($urandom_range(7) == 0) b[c] = ~b[c];
                if ($urandom_range(29) == 0) clr[c] = ~clr[c];
                if ($urandom_range(19) == 0)
                    setw(c, ($urandom_range(5) == 0) ? 0 : $urandom_range(12));
            end
            cyc(1);
        end
        cyc(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog (%s): actual=timeout expected=finish", tag);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule